// File: doc/BRIEF.md
# LDPC Syndrome Check Unit

This block sits at the end of each iteration of an iterative min-sum decoder for a 12-bit low-density parity-check code. It takes the twelve signed posterior values of the current iteration and slices each to a hard bit from its sign. It then evaluates the six parity equations of a fixed parity-check matrix on that estimate. The registered result reports the estimated word, the syndrome vector and whether the estimate is a valid codeword.

A small iteration controller counts the strobes of the current codeword. It raises terminate when the syndrome is clean, or when the programmable iteration limit is reached. In the second case it also raises fail, which tells the decoder to give up on the word. Once terminate has fired, the next strobe is counted as iteration 1 of a new codeword.

Top module: `ldpc_syn_check`

## Requirements
- R1: Hard bit c (hard_o[c], column c, 0-based) is 1 when posterior value c, read as two's complement from post_i[c*W +: W], is negative, and 0 when it is zero or positive.
- R2: syndrome_o[r] is the XOR of the hard bits in the columns of row r of the check matrix. The column masks are: row0 12'h00F, row1 12'h0F0, row2 12'h322, row3 12'hC88, row4 12'h511, row5 12'hA44 (bit c of a mask is column c).
- R3: syn_zero_o is 1 exactly when all six syndrome bits of the same result are 0.
- R4: A strobe on valid_i sampled at one rising edge gives its result on all outputs after that same edge. out_valid_o is high for one cycle per strobe. hard_o, syndrome_o, syn_zero_o and iter_o hold their values between strobes.
- R5: terminate_o pulses together with out_valid_o when the syndrome is zero, with fail_o low. terminate_o is never high without out_valid_o.
- R6: iter_o gives the iteration number of the result: 1 for the first strobe after reset or after a terminate, and one more for each later strobe.
- R7: When the iteration number reaches or exceeds max_iter_i (sampled with the strobe) and the syndrome is nonzero, terminate_o and fail_o both pulse. A limit of 0 behaves like 1.
- R8: The strobe following a terminate starts a new codeword at iteration 1.
- R9: The scaled posterior vector [-48 28 -18 31 -29 18 -17 29 -40 -31 -36 -32] gives hard_o = 12'hF55 and an all-zero syndrome.
- R10: Every column belongs to exactly two rows, so each valid result has a syndrome of even weight.
- R11: While rst_ni is low, every output is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| valid_i | input | 1 | Posterior vector strobe, one per iteration |
| max_iter_i | input | ITER_W | Iteration limit |
| post_i | input | 12*W | Twelve signed posterior values, column c at [c*W +: W] |
| out_valid_o | output | 1 | Result strobe |
| hard_o | output | 12 | Hard-decision word |
| syndrome_o | output | 6 | Syndrome vector |
| syn_zero_o | output | 1 | Syndrome is all zero |
| terminate_o | output | 1 | Stop decoding this codeword |
| fail_o | output | 1 | Stopped on the limit with a nonzero syndrome |
| iter_o | output | ITER_W | Iteration number of the result |

## Verification
The bench feeds posterior values of exactly zero, minus one and the extremes of the range. A slicer that tests for nonpositive values instead of negative ones, or that takes the wrong bit as the sign, would flip those hard bits and the syndrome that follows from them. Sequences with nonzero syndromes run into limits of 0, 1 and 3, then are followed by a clean word. An off-by-one compare or a counter that is not cleared would end too early or too late, or would report the wrong iteration number on the next codeword. Random words, some built around the known codewords 12'h000, 12'hF55, 12'h0AA and 12'hFFF, catch a wrong mask column, because a valid word would then show a nonzero syndrome.

// File: rtl/ldpc_syn_pkg.sv
package ldpc_syn_pkg;
  localparam int unsigned N_COLS = 12;
  localparam int unsigned N_ROWS = 6;
  // bit c of row r set: column c takes part in parity equation r
  localparam logic [N_ROWS-1:0][N_COLS-1:0] H_MASK = {
    12'hA44, 12'h511, 12'hC88, 12'h322, 12'h0F0, 12'h00F
  };
endpackage

// File: rtl/ldpc_hard_slicer.sv
module ldpc_hard_slicer #(
  parameter int unsigned N = 12,
  parameter int unsigned W = 8
) (
  input  logic [N*W-1:0] post_i,
  output logic [N-1:0]   bits_o
);
  for (genvar c = 0; c < N; c++) begin : g_col
    // negative -> 1, zero or positive -> 0
    assign bits_o[c] = post_i[c*W + W - 1];
  end
endmodule

// File: rtl/ldpc_parity_eval.sv
module ldpc_parity_eval #(
  parameter int unsigned N = 12,
  parameter int unsigned R = 6,
  parameter logic [R-1:0][N-1:0] H = '0
) (
  input  logic [N-1:0] bits_i,
  output logic [R-1:0] syn_o
);
  for (genvar r = 0; r < R; r++) begin : g_row
    assign syn_o[r] = ^(bits_i & H[r]);
  end
endmodule

// File: rtl/ldpc_iter_ctrl.sv
module ldpc_iter_ctrl #(
  parameter int unsigned ITER_W = 5
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              step_i,
  input  logic              zero_i,
  input  logic [ITER_W-1:0] max_i,
  output logic              term_o,
  output logic              fail_o,
  output logic [ITER_W-1:0] iter_o
);
  logic [ITER_W-1:0] cnt_q;
  logic [ITER_W-1:0] nxt;
  logic              hit;

  assign nxt = cnt_q + 1'b1;
  assign hit = (nxt >= max_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      term_o <= 1'b0;
      fail_o <= 1'b0;
      iter_o <= '0;
    end else if (step_i) begin
      term_o <= zero_i | hit;
      fail_o <= ~zero_i & hit;
      iter_o <= nxt;
      cnt_q  <= (zero_i | hit) ? '0 : nxt;
    end else begin
      term_o <= 1'b0;
      fail_o <= 1'b0;
    end
  end

  // counter can never reach all ones: the limit stops it first
  assert_cnt_bound_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q != '1);
endmodule

// File: rtl/ldpc_syn_check.sv
module ldpc_syn_check
  import ldpc_syn_pkg::*;
#(
  parameter int unsigned W      = 8,
  parameter int unsigned ITER_W = 5
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  valid_i,
  input  logic [ITER_W-1:0]     max_iter_i,
  input  logic [N_COLS*W-1:0]   post_i,
  output logic                  out_valid_o,
  output logic [N_COLS-1:0]     hard_o,
  output logic [N_ROWS-1:0]     syndrome_o,
  output logic                  syn_zero_o,
  output logic                  terminate_o,
  output logic                  fail_o,
  output logic [ITER_W-1:0]     iter_o
);
  logic [N_COLS-1:0] bits_d;
  logic [N_ROWS-1:0] syn_d;
  logic              zero_d;

  ldpc_hard_slicer #(.N(N_COLS), .W(W)) u_slice (
    .post_i (post_i),
    .bits_o (bits_d)
  );

  ldpc_parity_eval #(.N(N_COLS), .R(N_ROWS), .H(H_MASK)) u_parity (
    .bits_i (bits_d),
    .syn_o  (syn_d)
  );

  assign zero_d = ~|syn_d;

  ldpc_iter_ctrl #(.ITER_W(ITER_W)) u_iter (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .step_i (valid_i),
    .zero_i (zero_d),
    .max_i  (max_iter_i),
    .term_o (terminate_o),
    .fail_o (fail_o),
    .iter_o (iter_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      out_valid_o <= 1'b0;
      hard_o      <= '0;
      syndrome_o  <= '0;
      syn_zero_o  <= 1'b0;
    end else begin
      out_valid_o <= valid_i;
      if (valid_i) begin
        hard_o     <= bits_d;
        syndrome_o <= syn_d;
        syn_zero_o <= zero_d;
      end
    end
  end

  assert_one_cycle_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_valid_o == $past(valid_i));

  assert_term_with_valid_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    terminate_o |-> out_valid_o);

  assert_iter_nonzero_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_valid_o |-> iter_o != '0);

  assert_fail_cause_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fail_o |-> terminate_o && !syn_zero_o);

  assert_even_syndrome_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_valid_o |-> ^syndrome_o == 1'b0);

  assert_clean_stops_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (out_valid_o && syn_zero_o) |-> (terminate_o && !fail_o));
endmodule

// File: tb/ldpc_syn_check_tb_top.sv
module ldpc_syn_check_tb_top;
  localparam int W = 8;
  localparam int N = 12;

  logic          clk_i = 1'b0;
  logic          rst_ni = 1'b0;
  logic          valid_i = 1'b0;
  logic [4:0]    max_iter_i = '0;
  logic [N*W-1:0] post_i = '0;
  logic          out_valid_o;
  logic [11:0]   hard_o;
  logic [5:0]    syndrome_o;
  logic          syn_zero_o;
  logic          terminate_o;
  logic          fail_o;
  logic [4:0]    iter_o;

  int checks = 0;
  int failures = 0;
  int exp_cnt = 0;
  bit finished = 1'b0;

  // R2 masks as stated in the requirement
  logic [11:0] masks [6] = '{12'h00F, 12'h0F0, 12'h322, 12'hC88, 12'h511, 12'hA44};
  logic [11:0] cwords [4] = '{12'h000, 12'hF55, 12'h0AA, 12'hFFF};

  always #5 clk_i = ~clk_i;

  ldpc_syn_check dut_i (
    .clk_i(clk_i), .rst_ni(rst_ni), .valid_i(valid_i), .max_iter_i(max_iter_i),
    .post_i(post_i), .out_valid_o(out_valid_o), .hard_o(hard_o),
    .syndrome_o(syndrome_o), .syn_zero_o(syn_zero_o), .terminate_o(terminate_o),
    .fail_o(fail_o), .iter_o(iter_o)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [11:0] ref_hard(input logic [N*W-1:0] v);
    logic [11:0] h;
    for (int c = 0; c < N; c++) h[c] = ($signed(v[c*W +: W]) < 0);
    return h;
  endfunction

  function automatic logic [5:0] ref_syn(input logic [11:0] h);
    logic [5:0] s;
    for (int r = 0; r < 6; r++) begin
      s[r] = 1'b0;
      for (int c = 0; c < N; c++) if (masks[r][c]) s[r] = s[r] ^ h[c];
    end
    return s;
  endfunction

  task automatic strobe(input logic [N*W-1:0] v, input logic [4:0] mx, input string tag);
    logic [11:0] eh;
    logic [5:0]  es;
    bit ez, eterm, efail;
    int n;
    eh = ref_hard(v);
    es = ref_syn(eh);
    ez = (es == 6'd0);
    n = exp_cnt + 1;
    eterm = ez || (n >= int'(mx));
    efail = eterm && !ez;
    exp_cnt = eterm ? 0 : n;
    @(negedge clk_i);
    post_i = v; max_iter_i = mx; valid_i = 1'b1;
    @(negedge clk_i);
    valid_i = 1'b0;
    post_i = ~v;
    chk(out_valid_o == 1'b1, {"R4 out_valid ", tag}, out_valid_o, 1);
    chk(hard_o == eh, {"R1 hard ", tag}, hard_o, eh);
    chk(syndrome_o == es, {"R2 syndrome ", tag}, syndrome_o, es);
    chk(syn_zero_o == ez, {"R3 zero ", tag}, syn_zero_o, ez);
    chk(terminate_o == eterm, {"R5 R7 terminate ", tag}, terminate_o, eterm);
    chk(fail_o == efail, {"R7 fail ", tag}, fail_o, efail);
    chk(int'(iter_o) == n, {"R6 R8 iter ", tag}, iter_o, n);
  endtask

  task automatic hold_check(input string tag);
    logic [11:0] h;
    logic [5:0]  s;
    h = hard_o; s = syndrome_o;
    @(negedge clk_i);
    chk(out_valid_o == 1'b0, {"R4 pulse ", tag}, out_valid_o, 0);
    chk(terminate_o == 1'b0 && fail_o == 1'b0, {"R5 no term ", tag}, {terminate_o, fail_o}, 0);
    chk(hard_o == h && syndrome_o == s, {"R4 hold ", tag}, {hard_o, syndrome_o}, {h, s});
  endtask

  function automatic logic [N*W-1:0] pack(input int vals [12]);
    logic [N*W-1:0] b;
    for (int c = 0; c < N; c++) b[c*W +: W] = vals[c][W-1:0];
    return b;
  endfunction

  function automatic logic [N*W-1:0] rand_word(input logic [11:0] signs);
    logic [N*W-1:0] b;
    for (int c = 0; c < N; c++) begin
      int m;
      m = $urandom_range(127, 0);
      b[c*W +: W] = signs[c] ? W'(-m) : W'(m);
    end
    return b;
  endfunction

  initial begin
    #2_000_000;
    if (!finished) begin
      failures++;
      checks++;
      $display("FAIL watchdog expired actual=0 expected=1");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    int ex [12] = '{-48, 28, -18, 31, -29, 18, -17, 29, -40, -31, -36, -32};
    int edge_v [12] = '{0, -1, 1, -128, 127, 0, -1, 0, 0, 0, 0, 0};
    void'($urandom(32'd4242));
    repeat (3) @(negedge clk_i);
    // R11 reset state
    chk({out_valid_o, hard_o, syndrome_o, syn_zero_o, terminate_o, fail_o, iter_o} == '0,
        "R11 reset", {hard_o, syndrome_o}, 0);
    rst_ni = 1'b1;
    @(negedge clk_i);

    // R9 worked example
    strobe(pack(ex), 5'd8, "R9 example");
    chk(hard_o == 12'hF55 && syndrome_o == 6'd0, "R9 example word", hard_o, 12'hF55);
    hold_check("after example");

    // R1 zero, -1 and extremes
    strobe(pack(edge_v), 5'd8, "R1 edges");
    chk(hard_o == 12'h04A, "R1 edge bits", hard_o, 12'h04A);
    strobe('0, 5'd8, "R1 all zero");

    // R7 limit of 3 with a dirty word, then R8 restart with a clean word
    strobe(pack(edge_v), 5'd3, "R7 lim3 a");
    strobe(pack(edge_v), 5'd3, "R7 lim3 b");
    strobe(pack(edge_v), 5'd3, "R7 lim3 c");
    strobe(pack(ex), 5'd3, "R8 restart");
    // R7 limit 0 and 1 end the first iteration
    strobe(pack(edge_v), 5'd0, "R7 lim0");
    strobe(pack(edge_v), 5'd1, "R7 lim1");
    hold_check("after limit");

    // random mix
    for (int i = 0; i < 300; i++) begin
      logic [11:0] sg;
      logic [4:0] mx;
      sg = ($urandom_range(1, 0) == 1) ? cwords[$urandom_range(3, 0)] : 12'($urandom());
      mx = 5'($urandom_range(8, 0));
      strobe(rand_word(sg), mx, "random");
      if ($urandom_range(3, 0) == 0) hold_check("random gap");
    end

    finished = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule